// File: doc/BRIEF.md
# Thermal Event Duration Accumulator

This block measures how long an active-low thermal throttle line has been held low, summed over any number of separate events. A shared pin is first passed through a two-flop synchronizer. When the block is configured to treat that pin as the thermal timer input, every timebase tick that arrives while the line is low adds one count to a saturating accumulator. Software reads the total at whatever interval it likes. The read strobe returns the current total on `timer_value` and clears the total and the alert on the next edge.

The upper bits of the total are compared with an 8-bit programmable limit. When the total exceeds the limit, a sticky alert is raised unless the mask bit is set. A limit of zero changes the meaning of the threshold: the alert then fires on the very first low level of the input. Separately, a boost option can push the fan duties to full scale while the line is low. The boost applies only to fans that are already running, so a fan with zero duty stays stopped.

Top module: `thermal_dwell_accum`

## Requirements
- R1: After reset, `timer_value` is 0, `alert` is 0 and `duty_out` equals `duty_in`.
- R2: With the timer role active, each cycle that has `tick` high and the synchronized input low adds exactly 1 to `timer_value`. The synchronized input follows the pin two clock edges late. While the input is high, ticks add nothing.
- R3: The timer role is active only when `cfg_timer_en` is 1 and `cfg_pin_func` equals 2'b11. In any other setting the pin is ignored: the total does not count, the fans are not forced, and the limit-zero alert does not fire.
- R4: The total is kept across separate low events and is not restarted when a new event begins.
- R5: The total stops at 2^CNT_W-1 and does not wrap.
- R6: For a nonzero limit, `alert` sets on the edge after `timer_value >> (CNT_W-8)` becomes greater than `limit`. Once set, it stays set until a read.
- R7: With `limit` equal to 0, `alert` sets on the edge after any cycle in which the timer role is active and the synchronized input is low, even if no tick has arrived.
- R8: While `cfg_alert_mask` is 1, `alert` does not go from 0 to 1.
- R9: A cycle with `rd_strobe` high clears `alert` and the total on the next edge. If a counting tick falls in that same cycle, the total restarts at 1 instead of 0.
- R10: With `cfg_boost` 1, the timer role active and the synchronized input low, every fan slice of `duty_in` that is nonzero appears on `duty_out` as all ones.
- R11: A fan slice of `duty_in` that is zero is always zero on `duty_out`.
- R12: With `cfg_boost` 0, `duty_out` always equals `duty_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_pin_n | input | 1 | Shared pin, active-low thermal throttle when in timer role |
| tick | input | 1 | Timebase pulse, one count per high cycle |
| cfg_timer_en | input | 1 | Timer enable |
| cfg_pin_func | input | 2 | Pin role select; 2'b11 selects the thermal timer |
| cfg_boost | input | 1 | Force running fans to full duty during events |
| cfg_alert_mask | input | 1 | Blocks the alert from setting |
| limit | input | 8 | Threshold compared with the top 8 bits of the total |
| rd_strobe | input | 1 | Read: total is valid this cycle, cleared with the alert after it |
| duty_in | input | N_FANS*DUTY_W | Current fan duties, fan 0 in the low bits |
| timer_value | output | CNT_W | Accumulated low time in ticks |
| alert | output | 1 | Sticky threshold alert |
| duty_out | output | N_FANS*DUTY_W | Fan duties after the boost override |

## Verification
The read strobe and a counting tick can land in the same cycle. So can the read strobe and an alert condition that is still true. The bench holds the pin low, pulses `rd_strobe` together with `tick`, and expects a total of 1 rather than 0. It also reads with a zero limit while the line is still low, and expects `alert` to be 0 for exactly one cycle and then set again.

// File: rtl/tdacc_pkg.sv
package tdacc_pkg;

   typedef enum logic [1:0] {
      PF_TACH_A      = 2'b00,
      PF_TACH_B      = 2'b01,
      PF_TACH_C      = 2'b10,
      PF_THERM_TIMER = 2'b11
   } pin_func_e;

   function automatic logic timer_role(input logic en, input logic [1:0] pf);
      return en && (pf == PF_THERM_TIMER);
   endfunction

endpackage

// File: rtl/tdacc_sync.sv
module tdacc_sync #(
   parameter int         STAGES    = 2,
   parameter logic       RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tdacc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tdacc_accum.sv
module tdacc_accum #(
   parameter int CNT_W    = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clear,
   output logic [CNT_W-1:0] acc
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_width
      $error("tdacc_accum: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] acc_q, acc_step;

   if (SATURATE) begin : g_sat
      assign acc_step = (acc_q == CNT_MAX) ? acc_q : acc_q + CNT_ONE;
   end else begin : g_wrap
      assign acc_step = acc_q + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clear)  acc_q <= inc ? CNT_ONE : '0;
      else if (inc)    acc_q <= acc_step;
   end

   assign acc = acc_q;
endmodule

// File: rtl/tdacc_alert.sv
module tdacc_alert #(
   parameter int CNT_W   = 10,
   parameter int LIMIT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   acc,
   input  logic [LIMIT_W-1:0] limit,
   input  logic               event_now,
   input  logic               mask,
   input  logic               clear,
   output logic               alert
);
   if (CNT_W < LIMIT_W) begin : g_bad_cmp
      $error("tdacc_alert: CNT_W must not be smaller than LIMIT_W");
   end

   logic [LIMIT_W-1:0] acc_hi;
   logic               limit_zero, over, trip, alert_q;

   assign acc_hi     = acc[CNT_W-1 -: LIMIT_W];
   assign limit_zero = (limit == '0);
   assign over       = acc_hi > limit;
   assign trip       = !mask && (limit_zero ? event_now : over);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     alert_q <= 1'b0;
      else if (clear) alert_q <= 1'b0;
      else if (trip)  alert_q <= 1'b1;
   end

   assign alert = alert_q;
endmodule

// File: rtl/tdacc_fan_force.sv
module tdacc_fan_force #(
   parameter int N_FANS = 3,
   parameter int DUTY_W = 8
) (
   input  logic                     force_full,
   input  logic [N_FANS*DUTY_W-1:0] duty_in,
   output logic [N_FANS*DUTY_W-1:0] duty_out
);
   localparam logic [DUTY_W-1:0] DUTY_FULL = {DUTY_W{1'b1}};

   if (N_FANS < 1) begin : g_bad_fans
      $error("tdacc_fan_force: N_FANS must be at least 1");
   end

   for (genvar f = 0; f < N_FANS; f++) begin : g_fan
      logic [DUTY_W-1:0] cur;
      logic              spinning;
      assign cur      = duty_in[f*DUTY_W +: DUTY_W];
      assign spinning = (cur != '0);
      assign duty_out[f*DUTY_W +: DUTY_W] = (force_full && spinning) ? DUTY_FULL : cur;
   end
endmodule

// File: rtl/thermal_dwell_accum.sv
module thermal_dwell_accum #(
   parameter int CNT_W       = 10,
   parameter int LIMIT_W     = 8,
   parameter int N_FANS      = 3,
   parameter int DUTY_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     therm_pin_n,
   input  logic                     tick,
   input  logic                     cfg_timer_en,
   input  logic [1:0]               cfg_pin_func,
   input  logic                     cfg_boost,
   input  logic                     cfg_alert_mask,
   input  logic [LIMIT_W-1:0]       limit,
   input  logic                     rd_strobe,
   input  logic [N_FANS*DUTY_W-1:0] duty_in,
   output logic [CNT_W-1:0]         timer_value,
   output logic                     alert,
   output logic [N_FANS*DUTY_W-1:0] duty_out
);
   import tdacc_pkg::*;

   logic pin_sync_n;
   logic timer_active;
   logic therm_asserted;
   logic count_now;

   tdacc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (therm_pin_n),
      .q     (pin_sync_n)
   );

   assign timer_active   = timer_role(cfg_timer_en, cfg_pin_func);
   assign therm_asserted = !pin_sync_n;
   assign count_now      = timer_active && therm_asserted && tick;

   tdacc_accum #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (count_now),
      .clear (rd_strobe),
      .acc   (timer_value)
   );

   tdacc_alert #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) u_alert (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (timer_value),
      .limit     (limit),
      .event_now (timer_active && therm_asserted),
      .mask      (cfg_alert_mask),
      .clear     (rd_strobe),
      .alert     (alert)
   );

   tdacc_fan_force #(.N_FANS(N_FANS), .DUTY_W(DUTY_W)) u_fans (
      .force_full (cfg_boost && timer_active && therm_asserted),
      .duty_in    (duty_in),
      .duty_out   (duty_out)
   );
endmodule

// File: rtl/tdacc_checker.sv
module tdacc_checker #(
   parameter int CNT_W   = 10,
   parameter int LIMIT_W = 8,
   parameter int N_FANS  = 3,
   parameter int DUTY_W  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     timer_active,
   input logic                     therm_asserted,
   input logic                     cfg_boost,
   input logic                     cfg_alert_mask,
   input logic [LIMIT_W-1:0]       limit,
   input logic                     rd_strobe,
   input logic [N_FANS*DUTY_W-1:0] duty_in,
   input logic [CNT_W-1:0]         timer_value,
   input logic                     alert,
   input logic [N_FANS*DUTY_W-1:0] duty_out
);
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> (timer_value == $past(timer_value)) ||
                     (timer_value == $past(timer_value) + 1'b1));

   p_inactive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_active && !rd_strobe) |=> $stable(timer_value));

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((&timer_value) && !rd_strobe) |=> (&timer_value));

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alert && !rd_strobe) |=> alert);

   p_first_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0 && timer_active && therm_asserted && !cfg_alert_mask && !rd_strobe) |=> alert);

   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_alert_mask && !alert) |=> !alert);

   p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> (!alert && timer_value <= 1));

   p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_boost |-> (duty_out == duty_in));

   for (genvar f = 0; f < N_FANS; f++) begin : g_fan_chk
      p_zero_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (duty_in[f*DUTY_W +: DUTY_W] == '0) |-> (duty_out[f*DUTY_W +: DUTY_W] == '0));
      p_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_boost && timer_active && therm_asserted && duty_in[f*DUTY_W +: DUTY_W] != '0)
         |-> (&duty_out[f*DUTY_W +: DUTY_W]));
   end
endmodule

bind thermal_dwell_accum tdacc_checker #(
   .CNT_W(CNT_W), .LIMIT_W(LIMIT_W), .N_FANS(N_FANS), .DUTY_W(DUTY_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .timer_active   (timer_active),
   .therm_asserted (therm_asserted),
   .cfg_boost      (cfg_boost),
   .cfg_alert_mask (cfg_alert_mask),
   .limit          (limit),
   .rd_strobe      (rd_strobe),
   .duty_in        (duty_in),
   .timer_value    (timer_value),
   .alert          (alert),
   .duty_out       (duty_out)
);

// File: tb/tb_thermal_dwell_accum.sv
`timescale 1ns/1ps
module tb_thermal_dwell_accum;
   localparam int CNT_W = 10, LIMIT_W = 8, N_FANS = 3, DUTY_W = 8;
   localparam int SHIFT = CNT_W - LIMIT_W;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic therm_pin_n = 1'b1, tick = 1'b0, cfg_timer_en = 1'b0;
   logic [1:0] cfg_pin_func = 2'b00;
   logic cfg_boost = 1'b0, cfg_alert_mask = 1'b1, rd_strobe = 1'b0;
   logic [LIMIT_W-1:0] limit = 8'hFF;
   logic [N_FANS*DUTY_W-1:0] duty_in = '0;
   logic [CNT_W-1:0] timer_value;
   logic alert;
   logic [N_FANS*DUTY_W-1:0] duty_out;

   int n_checks = 0, n_fail = 0;
   int total = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   thermal_dwell_accum #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W), .N_FANS(N_FANS), .DUTY_W(DUTY_W)) dut (
      .clk(clk), .rst_n(rst_n), .therm_pin_n(therm_pin_n), .tick(tick),
      .cfg_timer_en(cfg_timer_en), .cfg_pin_func(cfg_pin_func), .cfg_boost(cfg_boost),
      .cfg_alert_mask(cfg_alert_mask), .limit(limit), .rd_strobe(rd_strobe),
      .duty_in(duty_in), .timer_value(timer_value), .alert(alert), .duty_out(duty_out));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; step();
      end
      tick = 1'b0;
   endtask

   task automatic set_pin(input logic v);
      therm_pin_n = v; step(2);
   endtask

   task automatic do_read();
      rd_strobe = 1'b1; step();
      rd_strobe = 1'b0;
      total = 0;
   endtask

   function automatic logic [N_FANS*DUTY_W-1:0] exp_duty(
      input logic [N_FANS*DUTY_W-1:0] din, input bit force_on);
      logic [N_FANS*DUTY_W-1:0] r;
      for (int f = 0; f < N_FANS; f++) begin
         logic [DUTY_W-1:0] d;
         d = din[f*DUTY_W +: DUTY_W];
         r[f*DUTY_W +: DUTY_W] = (force_on && d != 0) ? {DUTY_W{1'b1}} : d;
      end
      return r;
   endfunction

   initial begin
      #(8ns * 200000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] pats [5];
      pats[0] = 8'h00; pats[1] = 8'h01; pats[2] = 8'h80; pats[3] = 8'hFF; pats[4] = 8'h3C;
      duty_in = 24'h00_5A_01;
      step(3);
      // R1 reset state
      check(timer_value == 0, "R1 timer", timer_value, 0);
      check(alert == 0, "R1 alert", alert, 0);
      check(duty_out == duty_in, "R1 duty", duty_out, duty_in);
      rst_n = 1'b1; step();

      // Fan override sweep: R10 R11 R12 R3
      for (int en = 0; en < 2; en++)
         for (int pf = 0; pf < 4; pf++)
            for (int bst = 0; bst < 2; bst++)
               for (int pin = 0; pin < 2; pin++) begin
                  cfg_timer_en = en[0]; cfg_pin_func = pf[1:0]; cfg_boost = bst[0];
                  set_pin(pin[0]);
                  for (int p = 0; p < 5; p++) begin
                     bit fo;
                     duty_in = {pats[(p+2)%5], pats[(p+1)%5], pats[p]};
                     step();
                     fo = bst && en && pf == 3 && pin == 0;
                     check(duty_out == exp_duty(duty_in, fo),
                           bst ? (fo ? "R10 boost" : "R3 ignored") : "R12 pass",
                           duty_out, exp_duty(duty_in, fo));
                  end
                  set_pin(1'b1);
               end
      // R11 zero duty with boost forcing
      cfg_timer_en = 1; cfg_pin_func = 2'b11; cfg_boost = 1; duty_in = 24'h00_00_00;
      set_pin(0); step();
      check(duty_out == 0, "R11 zero fans", duty_out, 0);
      set_pin(1);
      do_read();

      // Accumulation over events: R2 R4
      cfg_boost = 0; cfg_alert_mask = 1; limit = 8'hFF;
      ticks(5);
      check(timer_value == 0, "R2 no count while high", timer_value, 0);
      begin
         int lens [4] = '{3, 0, 7, 12};
         foreach (lens[k]) begin
            set_pin(0); ticks(lens[k]); set_pin(1);
            total += lens[k];
            check(timer_value == total, "R4 running total", timer_value, total);
         end
      end
      // Synchronizer latency R2: tick on the first edge after the fall is not counted
      therm_pin_n = 0; tick = 1; step(); tick = 0; step();
      check(timer_value == total, "R2 sync latency", timer_value, total);
      ticks(1); total += 1;
      check(timer_value == total, "R2 count after sync", timer_value, total);
      // R3: other roles ignore the pin
      for (int pf = 0; pf < 3; pf++) begin
         cfg_pin_func = pf[1:0]; ticks(4);
         check(timer_value == total, "R3 pin func not timer", timer_value, total);
      end
      cfg_pin_func = 2'b11; cfg_timer_en = 0; ticks(4);
      check(timer_value == total, "R3 timer disabled", timer_value, total);
      cfg_timer_en = 1; set_pin(1);

      // R9 read clears, and read colliding with a counting tick
      do_read();
      check(timer_value == 0, "R9 read clears total", timer_value, 0);
      set_pin(0); ticks(3);
      rd_strobe = 1; tick = 1; step(); rd_strobe = 0; tick = 0;
      check(timer_value == 1, "R9 read with tick", timer_value, 1);

      // R5 saturation
      do_read(); ticks(CMAX + 8);
      check(timer_value == CMAX, "R5 saturate", timer_value, CMAX);
      set_pin(1); do_read();

      // R6 threshold sweep
      cfg_alert_mask = 0;
      for (int li = 0; li < 4; li++) begin
         int lv [4] = '{1, 2, 5, 40};
         int thr;
         limit = lv[li][7:0];
         thr = (lv[li] + 1) << SHIFT;
         set_pin(0); ticks(thr - 1); step();
         check(alert == 0, "R6 below limit", alert, 0);
         ticks(1); step();
         check(alert == 1, "R6 above limit", alert, 1);
         set_pin(1); step(3);
         check(alert == 1, "R6 sticky", alert, 1);
         do_read();
         check(alert == 0, "R9 read clears alert", alert, 0);
      end

      // R7 limit zero: first assertion, no tick needed
      limit = 0;
      set_pin(0); step();
      check(alert == 1, "R7 first assertion", alert, 1);
      check(timer_value == 0, "R7 no tick needed", timer_value, 0);
      rd_strobe = 1; step(); rd_strobe = 0;
      check(alert == 0, "R9 read with live event", alert, 0);
      step();
      check(alert == 1, "R7 re-raise after read", alert, 1);
      set_pin(1); do_read();
      // R3 limit zero inactive
      cfg_pin_func = 2'b01; set_pin(0); step(2);
      check(alert == 0, "R3 no alert when inactive", alert, 0);
      set_pin(1); cfg_pin_func = 2'b11;

      // R8 mask
      cfg_alert_mask = 1;
      set_pin(0); step(2);
      check(alert == 0, "R8 mask limit zero", alert, 0);
      limit = 1; ticks(40); step();
      check(alert == 0, "R8 mask over limit", alert, 0);
      set_pin(1); do_read();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule